// File: doc/BRIEF.md
# Windowed Watchdog Reset Timer

This block watches software for signs that it has stopped running correctly. A counter advances on a slow tick of about 1 kHz, one clock cycle wide and independent of the main clock's rate. If software does not pulse the service input in time, the block raises a one-cycle reset request for the system. The counter keeps advancing on every tick for as long as the block is enabled, whatever state the rest of the system is in.

The block has two modes. In plain mode, a service is accepted at any moment and starts a fresh timeout. In window mode, each period is split into two phases. A closed phase comes first, and a service during it counts as a fault. An open phase follows, and a service during it is the only valid one. Missing the end of the open phase is also a fault. A lock input freezes the configuration. After reset, the configuration is loaded from static default inputs.

Top module: `wdg_window_timer`

## Requirements
- R1: A 4-bit period code c from 0 to 10 selects a length of 8·2^c ticks (8 up to 8192). Codes 11 to 15 select 8192 ticks. The window code uses the same encoding.
- R2: In plain mode (mode bit 0), if no service arrives, `resetReq` is high for the cycle after the clock edge that captures the tick completing the selected period.
- R3: In plain mode, a service at any time clears the count, so a full new period follows it. A service in plain mode never produces a reset request.
- R4: In window mode (mode bit 1), the closed phase lasts the number of ticks given by the window code. A service inside the closed phase, including on the last closed tick, produces a reset request.
- R5: In window mode, a service in the open phase clears the count and returns to the closed phase. If the open phase runs for its full period length without a service, a reset request follows.
- R6: While `rstN` is low, enable, mode, period code and window code load from the `dflt*` inputs. `resetReq` is low after reset.
- R7: While `cfgLock` is high, a `cfgWrite` has no effect on enable, mode, period code or window code.
- R8: While disabled, the block produces no reset request and ignores ticks and services. Enabling it starts a count from zero.
- R9: `resetReq` is high for exactly one cycle per fault. The count then restarts from zero in the closed phase.
- R10: An accepted write that changes any configuration field clears the count and the phase. A write of identical values leaves the count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle slow count tick (~1 kHz) |
| service | input | 1 | One-cycle service strobe from software |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgLock | input | 1 | Blocks configuration writes while high |
| wrEnable | input | 1 | Enable value to write |
| wrWindowMode | input | 1 | Mode value to write (1 = window mode) |
| wrPeriodSel | input | 4 | Period code to write |
| wrWindowSel | input | 4 | Window (closed-phase) code to write |
| dfltEnable | input | 1 | Enable value loaded at reset |
| dfltWindowMode | input | 1 | Mode value loaded at reset |
| dfltPeriodSel | input | 4 | Period code loaded at reset |
| dfltWindowSel | input | 4 | Window code loaded at reset |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The only observable output is the reset request, so any wrong internal count or phase shows up as a request that comes at the wrong tick, or as a request that is missing or extra. An off-by-one in the count moves the request by one tick relative to the expected period boundary. A phase held wrongly turns a legal service into a fault, or lets an early service pass silently. A wrong count can stay hidden for up to one full period, which is as long as 8192 ticks, so each check waits until a period boundary and counts the request pulses seen there.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  parameter int CODE_W     = 4;   // width of period / window codes
  parameter int NUM_CODES  = 11;  // number of distinct period lengths
  parameter int BASE_SHIFT = 3;   // shortest period is 2**BASE_SHIFT ticks

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // zero the count
    logic inc;        // advance the count by one
    logic useWindow;  // compare against the window length instead of the period
  } dpCtrl_t;

  typedef enum logic {
    PH_CLOSED = 1'b0,
    PH_OPEN   = 1'b1
  } phase_t;
endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CODE_W     = wdg_pkg::CODE_W,
  parameter int NUM_CODES  = wdg_pkg::NUM_CODES,
  parameter int BASE_SHIFT = wdg_pkg::BASE_SHIFT,
  parameter int CNT_W      = BASE_SHIFT + NUM_CODES
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [CODE_W-1:0] periodSel,
  input  logic [CODE_W-1:0] windowSel,
  output logic              hitLimit,
  output logic [CNT_W-1:0]  count
);
  localparam int NUM_SEL = 1 << CODE_W;

  logic [CNT_W-1:0] limitTable [NUM_SEL];
  logic [CNT_W-1:0] activeLimit;
  logic [CNT_W-1:0] countQ;

  // length decode: codes past the last valid one saturate at the longest length
  for (genvar c = 0; c < NUM_SEL; c++) begin : gLimit
    localparam int SH = (c < NUM_CODES) ? c : NUM_CODES - 1;
    localparam logic [CNT_W-1:0] LEN = CNT_W'(1) << (BASE_SHIFT + SH);
    assign limitTable[c] = LEN;
  end

  assign activeLimit = ctl.useWindow ? limitTable[windowSel] : limitTable[periodSel];
  assign hitLimit    = (countQ == activeLimit - CNT_W'(1));
  assign count       = countQ;

  always_ff @(posedge clk) begin
    if (!rstN)          countQ <= '0;
    else if (ctl.clear) countQ <= '0;
    else if (ctl.inc)   countQ <= countQ + CNT_W'(1);
  end

  // count never reaches the decoded length of the phase being timed
  assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    countQ < activeLimit);
endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int CODE_W = wdg_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              service,
  input  logic              cfgWrite,
  input  logic              cfgLock,
  input  logic              wrEnable,
  input  logic              wrWindowMode,
  input  logic [CODE_W-1:0] wrPeriodSel,
  input  logic [CODE_W-1:0] wrWindowSel,
  input  logic              dfltEnable,
  input  logic              dfltWindowMode,
  input  logic [CODE_W-1:0] dfltPeriodSel,
  input  logic [CODE_W-1:0] dfltWindowSel,
  input  logic              hitLimit,
  output dpCtrl_t           ctl,
  output logic [CODE_W-1:0] periodSel,
  output logic [CODE_W-1:0] windowSel,
  output logic              resetReq
);
  logic              enableQ;
  logic              modeQ;
  logic [CODE_W-1:0] periodQ;
  logic [CODE_W-1:0] windowQ;
  phase_t            phaseQ, phaseNext;
  logic              reqQ, reqNext;
  logic              cfgAccept;
  logic              cfgChanged;
  logic              inClosedWindow;

  assign cfgAccept  = cfgWrite && !cfgLock;
  assign cfgChanged = cfgAccept &&
                      ((wrEnable != enableQ) || (wrWindowMode != modeQ) ||
                       (wrPeriodSel != periodQ) || (wrWindowSel != windowQ));

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= dfltEnable;
      modeQ   <= dfltWindowMode;
      periodQ <= dfltPeriodSel;
      windowQ <= dfltWindowSel;
    end else if (cfgAccept) begin
      enableQ <= wrEnable;
      modeQ   <= wrWindowMode;
      periodQ <= wrPeriodSel;
      windowQ <= wrWindowSel;
    end
  end

  assign inClosedWindow = modeQ && (phaseQ == PH_CLOSED);

  always_comb begin
    ctl           = '0;
    ctl.useWindow = inClosedWindow;
    phaseNext     = phaseQ;
    reqNext       = 1'b0;
    if (!enableQ || cfgChanged) begin
      ctl.clear = 1'b1;
      phaseNext = PH_CLOSED;
    end else if (service) begin
      ctl.clear = 1'b1;
      phaseNext = PH_CLOSED;
      reqNext   = inClosedWindow;     // service before the window opens
    end else if (tick) begin
      if (hitLimit) begin
        ctl.clear = 1'b1;
        if (inClosedWindow) begin
          phaseNext = PH_OPEN;
        end else begin
          phaseNext = PH_CLOSED;
          reqNext   = 1'b1;           // period expired unserviced
        end
      end else begin
        ctl.inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_CLOSED;
      reqQ   <= 1'b0;
    end else begin
      phaseQ <= phaseNext;
      reqQ   <= reqNext;
    end
  end

  assign periodSel = periodQ;
  assign windowSel = windowQ;
  assign resetReq  = reqQ;

  assert_req_has_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(enableQ) && $past(service || tick));

  assert_plain_service_safe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && !modeQ && service) |=> !resetReq);

  assert_early_service_faults_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && modeQ && phaseQ == PH_CLOSED && service && !cfgChanged) |=> resetReq);

  assert_lock_freezes_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgLock |=> ($stable(enableQ) && $stable(modeQ) && $stable(periodQ) && $stable(windowQ)));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !resetReq);

  assert_req_resets_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> phaseQ == PH_CLOSED);
endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
  import wdg_pkg::*;
#(
  parameter int CODE_W     = wdg_pkg::CODE_W,
  parameter int NUM_CODES  = wdg_pkg::NUM_CODES,
  parameter int BASE_SHIFT = wdg_pkg::BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              service,
  input  logic              cfgWrite,
  input  logic              cfgLock,
  input  logic              wrEnable,
  input  logic              wrWindowMode,
  input  logic [CODE_W-1:0] wrPeriodSel,
  input  logic [CODE_W-1:0] wrWindowSel,
  input  logic              dfltEnable,
  input  logic              dfltWindowMode,
  input  logic [CODE_W-1:0] dfltPeriodSel,
  input  logic [CODE_W-1:0] dfltWindowSel,
  output logic              resetReq
);
  localparam int CNT_W = BASE_SHIFT + NUM_CODES;

  dpCtrl_t           dpCtl;
  logic              hitLimit;
  logic [CNT_W-1:0]  count;
  logic [CODE_W-1:0] periodSel;
  logic [CODE_W-1:0] windowSel;

  wdg_control #(.CODE_W(CODE_W)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .tick          (tick),
    .service       (service),
    .cfgWrite      (cfgWrite),
    .cfgLock       (cfgLock),
    .wrEnable      (wrEnable),
    .wrWindowMode  (wrWindowMode),
    .wrPeriodSel   (wrPeriodSel),
    .wrWindowSel   (wrWindowSel),
    .dfltEnable    (dfltEnable),
    .dfltWindowMode(dfltWindowMode),
    .dfltPeriodSel (dfltPeriodSel),
    .dfltWindowSel (dfltWindowSel),
    .hitLimit      (hitLimit),
    .ctl           (dpCtl),
    .periodSel     (periodSel),
    .windowSel     (windowSel),
    .resetReq      (resetReq)
  );

  wdg_datapath #(
    .CODE_W    (CODE_W),
    .NUM_CODES (NUM_CODES),
    .BASE_SHIFT(BASE_SHIFT),
    .CNT_W     (CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .periodSel(periodSel),
    .windowSel(windowSel),
    .hitLimit (hitLimit),
    .count    (count)
  );

  // after a fault the timing restarts from an empty count
  assert_restart_from_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> count == '0);
endmodule

// File: tb/tb_wdg_window_timer.sv
module tb_wdg_window_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       service = 1'b0;
  logic       cfgWrite = 1'b0;
  logic       cfgLock = 1'b0;
  logic       wrEnable = 1'b0;
  logic       wrWindowMode = 1'b0;
  logic [3:0] wrPeriodSel = '0;
  logic [3:0] wrWindowSel = '0;
  logic       dfltEnable = 1'b1;
  logic       dfltWindowMode = 1'b0;
  logic [3:0] dfltPeriodSel = '0;
  logic [3:0] dfltWindowSel = '0;
  logic       resetReq;

  int testsRun = 0;
  int testsFailed = 0;
  int reqCount = 0;
  int reqBase = 0;
  int widthErrors = 0;
  logic prevReq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_window_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .service(service),
    .cfgWrite(cfgWrite), .cfgLock(cfgLock),
    .wrEnable(wrEnable), .wrWindowMode(wrWindowMode),
    .wrPeriodSel(wrPeriodSel), .wrWindowSel(wrWindowSel),
    .dfltEnable(dfltEnable), .dfltWindowMode(dfltWindowMode),
    .dfltPeriodSel(dfltPeriodSel), .dfltWindowSel(dfltWindowSel),
    .resetReq(resetReq)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && resetReq) reqCount++;
    if (rstN && resetReq && prevReq) widthErrors++;
    prevReq <= rstN && resetReq;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic mark();
    reqBase = reqCount;
  endtask

  task automatic expectReq(input int exp, input string tag, input string what);
    @(negedge clk);
    check((reqCount - reqBase) == exp, tag, what, reqCount - reqBase, exp);
    reqBase = reqCount;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic serviceOnce();
    @(negedge clk) service = 1'b1;
    @(negedge clk) service = 1'b0;
  endtask

  task automatic writeCfg(input bit en, input bit mode, input int per, input int win);
    @(negedge clk);
    cfgWrite = 1'b1; wrEnable = en; wrWindowMode = mode;
    wrPeriodSel = 4'(per); wrWindowSel = 4'(win);
    @(negedge clk) cfgWrite = 1'b0;
  endtask

  task automatic applyReset(input bit en, input bit mode, input int per, input int win);
    @(negedge clk);
    rstN = 1'b0; dfltEnable = en; dfltWindowMode = mode;
    dfltPeriodSel = 4'(per); dfltWindowSel = 4'(win);
    tick = 1'b0; service = 1'b0; cfgWrite = 1'b0; cfgLock = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    reqBase = reqCount;
  endtask

  task automatic t_reset_defaults();
    applyReset(1, 0, 0, 0);
    check(resetReq == 1'b0, "R6", "resetReq after reset", int'(resetReq), 0);
    mark(); ticks(7); expectReq(0, "R2", "no request before 8th tick");
    ticks(1);         expectReq(1, "R6", "default period 8 expires");
  endtask

  task automatic t_restart_after_req();
    mark(); ticks(7); expectReq(0, "R9", "count restarted after request");
    ticks(1);         expectReq(1, "R9", "next period after request");
  endtask

  task automatic t_period_codes();
    int codes[4] = '{1, 3, 10, 13};
    int lens[4]  = '{16, 64, 8192, 8192};
    for (int k = 0; k < 4; k++) begin
      writeCfg(1, 0, codes[k], 0);
      mark(); ticks(lens[k] - 1); expectReq(0, "R1", $sformatf("code %0d early", codes[k]));
      ticks(1);                   expectReq(1, "R1", $sformatf("code %0d expiry", codes[k]));
    end
  endtask

  task automatic t_plain_service();
    writeCfg(1, 0, 0, 0);
    mark(); ticks(5); serviceOnce(); ticks(7);
    expectReq(0, "R3", "service restarts period");
    ticks(1); expectReq(1, "R3", "full period after service");
    for (int i = 0; i < 10; i++) begin
      ticks(3); serviceOnce();
    end
    expectReq(0, "R3", "frequent services never fault");
    ticks(8); expectReq(1, "R3", "expiry after last service");
  endtask

  task automatic t_cfg_change();
    ticks(5); writeCfg(1, 0, 1, 0);
    mark(); ticks(15); expectReq(0, "R10", "period change clears count");
    ticks(1);          expectReq(1, "R10", "new period from zero");
    ticks(5); writeCfg(1, 0, 1, 0);
    mark(); ticks(10); expectReq(0, "R10", "identical write keeps count");
    ticks(1);          expectReq(1, "R10", "identical write expiry at 16");
  endtask

  task automatic t_window();
    writeCfg(1, 1, 1, 0);   // closed 8, open 16
    mark(); ticks(3); serviceOnce(); expectReq(1, "R4", "early service faults");
    ticks(7); serviceOnce();         expectReq(1, "R4", "service on last closed tick faults");
    ticks(8); serviceOnce();         expectReq(0, "R5", "service in open phase accepted");
    ticks(8); ticks(15);             expectReq(0, "R5", "open phase not yet expired");
    ticks(1);                        expectReq(1, "R5", "late: open phase expired");
    writeCfg(1, 1, 1, 2);   // closed 32
    ticks(31); serviceOnce();        expectReq(1, "R4", "closed length 32 early");
    ticks(32); serviceOnce();        expectReq(0, "R4", "closed length 32 then open");
  endtask

  task automatic t_lock();
    writeCfg(1, 0, 0, 0);
    @(negedge clk) cfgLock = 1'b1;
    writeCfg(0, 1, 5, 5);
    mark(); ticks(7); expectReq(0, "R7", "locked write ignored, early");
    ticks(1);         expectReq(1, "R7", "locked write ignored, period 8 kept");
    @(negedge clk) cfgLock = 1'b0;
    writeCfg(0, 0, 0, 0);
  endtask

  task automatic t_disable();
    mark(); ticks(20); serviceOnce(); ticks(20);
    expectReq(0, "R8", "disabled block silent");
    writeCfg(1, 0, 0, 0);
    ticks(7); expectReq(0, "R8", "re-enable counts from zero");
    ticks(1); expectReq(1, "R8", "re-enabled expiry");
  endtask

  task automatic t_reset_variants();
    applyReset(0, 0, 0, 0);
    ticks(20); serviceOnce(); expectReq(0, "R6", "default disabled");
    applyReset(1, 1, 0, 0);
    ticks(3); serviceOnce();  expectReq(1, "R6", "default window mode");
    applyReset(1, 0, 2, 0);
    ticks(31); expectReq(0, "R6", "default period 32 early");
    ticks(1);  expectReq(1, "R6", "default period 32 expiry");
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG_CYCLES, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    t_reset_defaults();
    t_restart_after_req();
    t_period_codes();
    t_plain_service();
    t_cfg_change();
    t_window();
    t_lock();
    t_disable();
    t_reset_variants();
    check(widthErrors == 0, "R9", "request pulse width", widthErrors, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule